// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits between a host I/O bus and a local packet-buffer RAM. Software programs a current address, a remaining byte count and a ring window given as start and stop page numbers. It then streams data through a single data-port offset. Every data-port access moves 1, 2 or 4 bytes, chosen per access. After each access the engine advances the address and lowers the count by that width. When an advanced address lands on the ring stop boundary, it folds back to the ring start.

Only two windows of the local address space are backed by storage: the lowest 32 bytes, and a packet window starting at a parameter base. The default packet window is 0x4000 up to, but not including, 0x4800; setting `PKT_BYTES` to 32768 gives a 32 KiB window. Accesses outside both windows drop their write data and read back as all ones. When the count reaches zero, a completion flag in the interrupt status byte is set. The interrupt output is active while any status bit is both set and enabled in the mask byte.

Top module: `rdma_port`

## Requirements
- R1: After reset, every control register reads 0x00, `irq` is low and `io_rdata` is zero.
- R2: A data-port write with a non-zero count stores `io_wdata` little-endian, lowest address getting bits 7:0. The address then rises by the width and the count falls by the width. Both the ring-start and the low 32-byte window hold data.
- R3: A data-port read with a non-zero count returns the stored bytes little-endian, zero-extended to 32 bits, and advances address and count as in R2.
- R4: A 16-bit access uses the current address with bit 0 cleared, and a 32-bit access uses it with bits 1:0 cleared. The address increment starts from the uncleared value.
- R5: When an advanced address equals the stop page times 256, it becomes the start page times 256 instead.
- R6: When an access brings the count to zero, ISR bit 6 is set. `irq` is high exactly when some ISR bit and the same IMR bit are both 1.
- R7: A data-port write while the count is zero changes neither memory, address nor count.
- R8: A data-port read while the count is zero returns memory data and leaves address and count unchanged.
- R9: An access whose cleared address is neither below 32 nor in the packet window discards write data. Read data is 0xFF, 0xFFFF or 0xFFFFFFFF for 1-, 2- and 4-byte accesses. Address and count still advance.
- R10: Writing 1s to the ISR byte clears those bits. Offset 0x1F reads as zero.
- R11: The offsets are: 0x00 start page, 0x01 stop page, 0x02/0x03 address low/high, 0x04/0x05 count low/high, 0x06 ISR, 0x07 IMR, 0x10 data port. `io_size` encodes 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes. Control registers take `io_wdata[7:0]` and return their byte zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_valid | input | 1 | One bus access this cycle |
| io_write | input | 1 | 1 for write, 0 for read |
| io_addr | input | 5 | Port offset |
| io_size | input | 2 | Access width code |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
Every access is taken at the rising edge where `io_valid` is high. Register and memory effects are therefore visible to an access made on the following cycle. The read result appears in `io_rdata` on that same edge, one cycle after the request. `irq` follows the ISR and IMR registers combinationally, so it reflects an access that completes at an edge right after that edge. The bench drives on falling edges and samples on the falling edge after each access. It reads address and count back through the register offsets rather than probing state.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [4:0] OFF_DATA = 5'h10;
  localparam logic [4:0] OFF_RSTP = 5'h1F;
  localparam logic [2:0] REG_ISR  = 3'd6;
  localparam logic [2:0] REG_IMR  = 3'd7;
  localparam int DONE_BIT = 6;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rdma_ptr_unit.sv
module rdma_ptr_unit #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [2:0]    width,
  input  logic          wr_en,
  input  logic [2:0]    wr_off,
  input  logic [7:0]    wr_byte,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic [AW-9:0] start_pg,
  output logic [AW-9:0] stop_pg,
  output logic          done
);
  localparam int PW = AW - 8;

  logic [AW-1:0] addr_n, bump;
  logic [CW-1:0] cnt_n;
  logic [PW-1:0] start_n, stop_n;
  logic          en;

  assign en = step | wr_en;

  always_comb begin
    addr_n  = addr_q;
    cnt_n   = cnt_q;
    start_n = start_pg;
    stop_n  = stop_pg;
    done    = 1'b0;
    bump    = addr_q + AW'(width);
    if (step) begin
      addr_n = (bump == {stop_pg, 8'h00}) ? {start_pg, 8'h00} : bump;
      cnt_n  = cnt_q - CW'(width);
      done   = (cnt_n == '0);
    end else if (wr_en) begin
      case (wr_off)
        3'd0: start_n = wr_byte[PW-1:0];
        3'd1: stop_n  = wr_byte[PW-1:0];
        3'd2: addr_n[7:0] = wr_byte;
        3'd3: addr_n[AW-1:8] = wr_byte[PW-1:0];
        3'd4: cnt_n[7:0] = wr_byte;
        3'd5: cnt_n[CW-1:8] = wr_byte[CW-9:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      start_pg <= '0;
      stop_pg  <= '0;
    end else if (en) begin
      addr_q   <= addr_n;
      cnt_q    <= cnt_n;
      start_pg <= start_n;
      stop_pg  <= stop_n;
    end
  end
endmodule

// File: rtl/rdma_buf_ram.sv
module rdma_buf_ram #(
  parameter logic [15:0] PKT_BASE  = 16'h4000,
  parameter int          PKT_BYTES = 2048,
  parameter int          LOW_BYTES = 32
) (
  input  logic        clk,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int WORDS = (LOW_BYTES + PKT_BYTES) / 4;
  localparam int IW    = $clog2(WORDS);
  localparam logic [16:0] PKT_LO  = {1'b0, PKT_BASE};
  localparam logic [16:0] PKT_HI  = PKT_LO + 17'(PKT_BYTES);
  localparam logic [16:0] LOW_TOP = 17'(LOW_BYTES);
  localparam logic [16:0] LOW_WDS = 17'(LOW_BYTES / 4);

  logic [15:0] aaddr;
  logic [16:0] a17, widx;
  logic        hit, in_low, in_pkt;
  logic [IW-1:0] idx;
  logic [1:0]  lane;
  logic [3:0]  be;
  logic [7:0]  wb [4];
  logic [7:0]  rw [4];
  logic [31:0] word;

  always_comb begin
    case (size)
      2'd0:    aaddr = addr;
      2'd1:    aaddr = {addr[15:1], 1'b0};
      default: aaddr = {addr[15:2], 2'b00};
    endcase
    a17    = {1'b0, aaddr};
    in_low = a17 < LOW_TOP;
    in_pkt = (a17 >= PKT_LO) && (a17 < PKT_HI);
    hit    = in_low | in_pkt;
    widx   = in_low ? (a17 >> 2) : (LOW_WDS + ((a17 - PKT_LO) >> 2));
    idx    = hit ? widx[IW-1:0] : '0;
    lane   = aaddr[1:0];
    for (int l = 0; l < 4; l++) begin
      case (size)
        2'd0:    be[l] = (lane == 2'(l));
        2'd1:    be[l] = (lane[1] == l[1]);
        default: be[l] = 1'b1;
      endcase
      case (size)
        2'd0:    wb[l] = wdata[7:0];
        2'd1:    wb[l] = wdata[8*(l%2) +: 8];
        default: wb[l] = wdata[8*l +: 8];
      endcase
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && hit && be[g]) mem[idx] <= wb[g];
    end
    assign rw[g] = mem[idx];
  end

  assign word = {rw[3], rw[2], rw[1], rw[0]};

  always_comb begin
    case (size)
      2'd0:    rdata = hit ? {24'd0, word[8*lane +: 8]} : 32'h0000_00FF;
      2'd1:    rdata = hit ? {16'd0, (lane[1] ? word[31:16] : word[15:0])} : 32'h0000_FFFF;
      default: rdata = hit ? word : 32'hFFFF_FFFF;
    endcase
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter logic [15:0] PKT_BASE  = 16'h4000,
  parameter int          PKT_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_valid,
  input  logic        io_write,
  input  logic [4:0]  io_addr,
  input  logic [1:0]  io_size,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        irq
);
  import rdma_pkg::*;

  localparam int AW = 16;
  localparam int CW = 16;

  logic [1:0]    rs_q;
  logic          rst_q;
  logic          dp_hit, reg_hit, cnt_zero, step, ram_we, ptr_wr, done;
  logic [2:0]    width;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    start_pg, stop_pg;
  logic [7:0]    isr_q, isr_n, imr_q, imr_n, reg_byte;
  logic [31:0]   ram_rd, rdata_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  assign dp_hit   = io_valid && (io_addr == OFF_DATA);
  assign reg_hit  = io_valid && !io_addr[4] && !io_addr[3];
  assign width    = size_bytes(io_size);
  assign cnt_zero = (cnt_q == '0);
  assign step     = dp_hit && !cnt_zero;
  assign ram_we   = step && io_write;
  assign ptr_wr   = reg_hit && io_write && (io_addr[2:0] < 3'd6);

  rdma_ptr_unit #(.AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_q), .step(step), .width(width),
    .wr_en(ptr_wr), .wr_off(io_addr[2:0]), .wr_byte(io_wdata[7:0]),
    .addr_q(addr_q), .cnt_q(cnt_q), .start_pg(start_pg), .stop_pg(stop_pg),
    .done(done)
  );

  rdma_buf_ram #(.PKT_BASE(PKT_BASE), .PKT_BYTES(PKT_BYTES), .LOW_BYTES(32)) u_ram (
    .clk(clk), .we(ram_we), .addr(addr_q), .size(io_size),
    .wdata(io_wdata), .rdata(ram_rd)
  );

  always_comb begin
    isr_n = isr_q;
    imr_n = imr_q;
    if (reg_hit && io_write && io_addr[2:0] == REG_ISR) isr_n = isr_q & ~io_wdata[7:0];
    if (reg_hit && io_write && io_addr[2:0] == REG_IMR) imr_n = io_wdata[7:0];
    if (done) isr_n[DONE_BIT] = 1'b1;
  end

  always_comb begin
    case (io_addr[2:0])
      3'd0:    reg_byte = start_pg;
      3'd1:    reg_byte = stop_pg;
      3'd2:    reg_byte = addr_q[7:0];
      3'd3:    reg_byte = addr_q[15:8];
      3'd4:    reg_byte = cnt_q[7:0];
      3'd5:    reg_byte = cnt_q[15:8];
      3'd6:    reg_byte = isr_q;
      default: reg_byte = imr_q;
    endcase
    rdata_n = io_rdata;
    if (io_valid && !io_write) begin
      if (dp_hit)       rdata_n = ram_rd;
      else if (reg_hit) rdata_n = {24'd0, reg_byte};
      else              rdata_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      isr_q    <= '0;
      imr_q    <= '0;
      io_rdata <= '0;
    end else if (io_valid) begin
      isr_q    <= isr_n;
      imr_q    <= imr_n;
      io_rdata <= rdata_n;
    end
  end

  assign irq = |(isr_q & imr_q);
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_valid,
  input logic        io_write,
  input logic [4:0]  io_addr,
  input logic [1:0]  io_size,
  input logic [31:0] io_rdata,
  input logic [15:0] addr_q,
  input logic [15:0] cnt_q,
  input logic [7:0]  start_pg,
  input logic [7:0]  stop_pg,
  input logic [7:0]  isr_q
);
  logic dp;
  assign dp = io_valid && (io_addr == 5'h10);

  // R7
  zero_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && io_write && cnt_q == 16'd0) |=> ($stable(addr_q) && $stable(cnt_q)));

  // R8
  zero_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && !io_write && cnt_q == 16'd0) |=> ($stable(addr_q) && $stable(cnt_q)));

  // R2
  byte_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && cnt_q != 16'd0 && io_size == 2'd0 && (addr_q + 16'd1) != {stop_pg, 8'h00})
    |=> (addr_q == $past(addr_q) + 16'd1 && cnt_q == $past(cnt_q) - 16'd1));

  // R5
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && cnt_q != 16'd0 && io_size == 2'd1 && (addr_q + 16'd2) == {stop_pg, 8'h00})
    |=> (addr_q == {$past(start_pg), 8'h00}));

  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && cnt_q == 16'd1 && io_size == 2'd0) |=> isr_q[6]);

  // R10
  rst_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && io_addr == 5'h1F) |=> (io_rdata == 32'd0));
endmodule

bind rdma_port rdma_port_chk u_chk (
  .clk(clk), .rst_n(rst_q), .io_valid(io_valid), .io_write(io_write),
  .io_addr(io_addr), .io_size(io_size), .io_rdata(io_rdata),
  .addr_q(addr_q), .cnt_q(cnt_q), .start_pg(start_pg), .stop_pg(stop_pg),
  .isr_q(isr_q)
);

// File: tb/rdma_port_bench.sv
`timescale 1ns/1ps
module rdma_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic        io_write = 1'b0;
  logic [4:0]  io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rdma_port u_rdma_port (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .irq(irq)
  );

  // {req[3:0], chk, wr, addr[4:0], size[1:0], data/expect[31:0]}
  localparam int NV = 50;
  localparam logic [44:0] VEC [NV] = '{
    {4'd11, 1'b0, 1'b1, 5'h00, 2'd0, 32'h40},
    {4'd11, 1'b0, 1'b1, 5'h01, 2'd0, 32'h48},
    {4'd11, 1'b0, 1'b1, 5'h07, 2'd0, 32'h40},
    {4'd11, 1'b0, 1'b1, 5'h02, 2'd0, 32'h00},
    {4'd11, 1'b0, 1'b1, 5'h03, 2'd0, 32'h40},
    {4'd11, 1'b0, 1'b1, 5'h04, 2'd0, 32'h0C},
    {4'd11, 1'b0, 1'b1, 5'h05, 2'd0, 32'h00},
    {4'd11, 1'b1, 1'b0, 5'h00, 2'd0, 32'h40},       // R11 readback
    {4'd11, 1'b1, 1'b0, 5'h01, 2'd1, 32'h48},       // R11
    {4'd11, 1'b1, 1'b0, 5'h07, 2'd2, 32'h40},       // R11
    {4'd2,  1'b0, 1'b1, 5'h10, 2'd2, 32'h44332211},
    {4'd2,  1'b0, 1'b1, 5'h10, 2'd1, 32'h0000BEEF},
    {4'd2,  1'b0, 1'b1, 5'h10, 2'd0, 32'h5A},
    {4'd2,  1'b0, 1'b1, 5'h10, 2'd0, 32'hC3},
    {4'd2,  1'b1, 1'b0, 5'h02, 2'd0, 32'h08},       // R2 address
    {4'd2,  1'b1, 1'b0, 5'h04, 2'd0, 32'h04},       // R2 count
    {4'd3,  1'b0, 1'b1, 5'h02, 2'd0, 32'h00},
    {4'd3,  1'b0, 1'b1, 5'h04, 2'd0, 32'h08},
    {4'd3,  1'b1, 1'b0, 5'h10, 2'd0, 32'h11},       // R3
    {4'd4,  1'b1, 1'b0, 5'h10, 2'd1, 32'h2211},     // R4 at 0x4001
    {4'd4,  1'b1, 1'b0, 5'h02, 2'd0, 32'h03},       // R4 increment unaligned
    {4'd4,  1'b1, 1'b0, 5'h10, 2'd2, 32'h44332211}, // R4 at 0x4003
    {4'd3,  1'b1, 1'b0, 5'h10, 2'd0, 32'hC3},       // R3
    {4'd6,  1'b1, 1'b0, 5'h06, 2'd0, 32'h40},       // R6
    {4'd10, 1'b1, 1'b0, 5'h1F, 2'd0, 32'h00},       // R10
    {4'd10, 1'b0, 1'b1, 5'h06, 2'd0, 32'h40},
    {4'd10, 1'b1, 1'b0, 5'h06, 2'd0, 32'h00},       // R10 cleared
    {4'd9,  1'b0, 1'b1, 5'h02, 2'd0, 32'h00},
    {4'd9,  1'b0, 1'b1, 5'h03, 2'd0, 32'h01},
    {4'd9,  1'b0, 1'b1, 5'h04, 2'd0, 32'h08},
    {4'd9,  1'b1, 1'b0, 5'h10, 2'd2, 32'hFFFFFFFF}, // R9
    {4'd9,  1'b1, 1'b0, 5'h10, 2'd1, 32'h0000FFFF}, // R9
    {4'd9,  1'b1, 1'b0, 5'h10, 2'd0, 32'h000000FF}, // R9
    {4'd9,  1'b0, 1'b1, 5'h10, 2'd0, 32'h77},
    {4'd9,  1'b1, 1'b0, 5'h04, 2'd0, 32'h00},       // R9 count still advanced
    {4'd9,  1'b1, 1'b0, 5'h02, 2'd0, 32'h08},       // R9 address advanced
    {4'd6,  1'b1, 1'b0, 5'h06, 2'd0, 32'h40},       // R6
    {4'd6,  1'b0, 1'b1, 5'h06, 2'd0, 32'h40},
    {4'd2,  1'b0, 1'b1, 5'h02, 2'd0, 32'h1C},
    {4'd2,  1'b0, 1'b1, 5'h03, 2'd0, 32'h00},
    {4'd2,  1'b0, 1'b1, 5'h04, 2'd0, 32'h04},
    {4'd2,  1'b0, 1'b1, 5'h10, 2'd2, 32'hCAFEF00D},
    {4'd2,  1'b1, 1'b0, 5'h02, 2'd0, 32'h20},       // R2 low window
    {4'd2,  1'b0, 1'b1, 5'h02, 2'd0, 32'h1C},
    {4'd2,  1'b0, 1'b1, 5'h04, 2'd0, 32'h02},
    {4'd2,  1'b1, 1'b0, 5'h10, 2'd1, 32'h0000F00D}, // R2 low window data
    {4'd8,  1'b1, 1'b0, 5'h10, 2'd0, 32'hFE},       // R8
    {4'd8,  1'b1, 1'b0, 5'h02, 2'd0, 32'h1E},       // R8 address held
    {4'd8,  1'b0, 1'b1, 5'h06, 2'd0, 32'h40},
    {4'd8,  1'b1, 1'b0, 5'h06, 2'd0, 32'h00}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [4:0] a, input logic [1:0] sz,
                     input logic [31:0] d);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_size = sz; io_wdata = d;
    @(negedge clk);
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [1:0] sz,
                        input logic [31:0] exp);
    acc(1'b0, a, sz, 32'd0);
    check(req, io_rdata, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rdata", io_rdata, 32'd0);
    for (int r = 0; r < 8; r++) rd_chk("R1 reg", 5'(r), 2'd0, 32'd0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][39], VEC[i][38:34], VEC[i][33:32], VEC[i][31:0]);
      if (VEC[i][40]) begin
        checks++;
        if (io_rdata !== VEC[i][31:0]) begin
          fails++;
          $display("FAIL R%0d vector %0d: got %08h expected %08h",
                   VEC[i][44:41], i, io_rdata, VEC[i][31:0]);
        end
      end
    end

    // R5 ring wrap: start 0x40, stop 0x41, address 0x40FE
    acc(1'b1, 5'h00, 2'd0, 32'h40);
    acc(1'b1, 5'h01, 2'd0, 32'h41);
    acc(1'b1, 5'h02, 2'd0, 32'hFE);
    acc(1'b1, 5'h03, 2'd0, 32'h40);
    acc(1'b1, 5'h04, 2'd0, 32'h08);
    acc(1'b1, 5'h10, 2'd1, 32'h1234);
    rd_chk("R5 addr lo", 5'h02, 2'd0, 32'h00);
    rd_chk("R5 addr hi", 5'h03, 2'd0, 32'h40);
    rd_chk("R5 data at start", 5'h10, 2'd1, 32'h2211);

    // R7 / R8: zero-count write ignored, zero-count read returns data
    acc(1'b1, 5'h02, 2'd0, 32'h10);
    acc(1'b1, 5'h04, 2'd0, 32'h01);
    acc(1'b1, 5'h10, 2'd0, 32'h66);
    acc(1'b1, 5'h02, 2'd0, 32'h10);
    acc(1'b1, 5'h10, 2'd0, 32'h99);
    rd_chk("R7 addr held", 5'h02, 2'd0, 32'h10);
    rd_chk("R7 count held", 5'h04, 2'd0, 32'h00);
    rd_chk("R7 memory kept", 5'h10, 2'd0, 32'h66);
    rd_chk("R8 addr held", 5'h02, 2'd0, 32'h10);

    // R6 interrupt masking
    check("R6 irq set", {31'd0, irq}, 32'd1);
    acc(1'b1, 5'h07, 2'd0, 32'h00);
    check("R6 irq masked", {31'd0, irq}, 32'd0);
    acc(1'b1, 5'h07, 2'd0, 32'h40);
    check("R6 irq unmasked", {31'd0, irq}, 32'd1);
    acc(1'b1, 5'h06, 2'd0, 32'h40);
    check("R10 irq after clear", {31'd0, irq}, 32'd0);

    finish_run();
  end
endmodule